// File: doc/BRIEF.md
# Endian-Selectable Load/Store Byte Lane Unit

This unit connects a 64-bit register datapath to a byte-addressed data memory whose words are eight bytes wide. For a store, it spreads the register value over the eight memory byte lanes and raises one write strobe for each byte the access covers. For a load, it takes the covered bytes out of the memory read word, puts them in the right order and sign- or zero-extends them to 64 bits. The result is registered. The access size can be one, two, four or eight bytes.

A per-request mode bit selects the byte order. In little-endian order the lowest address holds the least significant byte of the value. In big-endian order it holds the most significant byte. The unit also checks natural alignment. A request whose address is not a multiple of its size is not performed: it raises a one-cycle fault and writes nothing to memory or to the load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: Memory byte lane k (bits 8k+7:8k of the memory word) holds the byte whose address has k in its three low bits.
- R2: Size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. An access is aligned exactly when the address is a multiple of its size, so one-byte accesses are always aligned.
- R3: A valid misaligned request raises `align_fault` in the following cycle for one cycle, and drives no write strobe in its own cycle.
- R4: A misaligned load leaves `ld_result` unchanged and does not raise `ld_valid`.
- R5: A valid aligned store asserts exactly the strobes of lanes offset to offset+size-1. No strobe is asserted for loads or when `req_valid` is low.
- R6: In little-endian order (`req_big_endian`=0), a store puts value byte i (byte 0 is least significant) in lane offset+i.
- R7: In big-endian order (`req_big_endian`=1), a store puts value byte size-1-i in lane offset+i.
- R8: Store write data repeats the low size bytes of the value, with the R6/R7 ordering, in every size-aligned group of lanes. Value bytes above the size are ignored.
- R9: A little-endian load builds result byte i from lane offset+i.
- R10: A big-endian load builds result byte i from lane offset+size-1-i.
- R11: When `req_signed` is 1, the result bits above the field copy the top bit of the field. When it is 0, they are zero.
- R12: `ld_result` and `ld_valid` update at the clock edge that ends the load request cycle. Reset clears `ld_result`, `ld_valid` and `align_fault` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend the load result |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_big_endian | input | 1 | Byte order: 1 = big-endian, 0 = little-endian |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Register value to store |
| mem_rdata | input | 64 | Memory read word, valid in the request cycle |
| mem_wdata | output | 64 | Memory write word |
| mem_wbe | output | 8 | Per-lane write strobes |
| ld_result | output | 64 | Registered, extended load value |
| ld_valid | output | 1 | `ld_result` updated by the previous request |
| align_fault | output | 1 | Previous request was misaligned |

## Verification
The assertions check on every cycle that:
- a fault always traces back to a misaligned request of the cycle before;
- misaligned or idle requests drive no strobes;
- a valid aligned store's strobe count equals its size;
- a fault leaves the load result untouched;
- a valid load result always follows an aligned load;
- unsigned byte loads clear the upper bits.

Only the bench's scenarios can show which lanes carry which bytes under each byte order, the replication pattern of store data, and sign extension of negative fields. The same holds for the exact strobe positions and for clearing by reset partway through a run.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

    typedef struct packed {
        logic        valid;
        logic        store;
        logic        sign_ext;
        acc_size_e   size;
        byte_order_e order;
    } acc_ctrl_t;

    typedef struct packed {
        logic        valid;
        logic        fault;
        logic [63:0] value;
    } load_rsp_t;

    // Number of bytes moved by an access of the given size, as a 4-bit count.
    function automatic logic [3:0] size_bytes(input acc_size_e s);
        return 4'd1 << s;
    endfunction

    // Position inside the value of the byte that sits at position pos of the group.
    function automatic logic [3:0] value_index(input logic [3:0] pos,
                                               input logic [3:0] nbytes,
                                               input byte_order_e order);
        return (order == ORDER_BIG) ? (nbytes - 4'd1 - pos) : pos;
    endfunction

endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_lane_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   offset_i,
    output logic               aligned_o
);
    logic [OFF_W:0] low_mask;

    always_comb begin
        low_mask  = (OFF_W+1)'(size_bytes(size_i)) - 1'b1;
        aligned_o = (offset_i & low_mask[OFF_W-1:0]) == '0;
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    parameter int OFF_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  acc_size_e          size_i,
    input  byte_order_e        order_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [8*LANES-1:0] data_i,
    output logic [8*LANES-1:0] wdata_o,
    output logic [LANES-1:0]   wbe_o
);
    logic [3:0] nbytes;
    logic [4:0] end_lane;

    always_comb begin
        nbytes   = size_bytes(size_i);
        end_lane = 5'(offset_i) + 5'(nbytes);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0] pos;
        logic [3:0] src;
        always_comb begin
            pos = 4'(k) & (nbytes - 4'd1);
            src = value_index(pos, nbytes, order_i);
            wdata_o[k*8 +: 8] = data_i[src[OFF_W-1:0]*8 +: 8];
            wbe_o[k] = en_i && (5'(k) >= 5'(offset_i)) && (5'(k) < end_lane);
        end
    end

    // R5: an asserted strobe set always covers exactly the access size
    assert_wbe_count_R5: assert property (@(posedge clk) disable iff (rst)
        (|wbe_o) |-> ($countones(wbe_o) == int'(size_bytes(size_i))));

    // R5: disabled stores drive no strobe
    assert_wbe_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (wbe_o == '0));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    parameter int OFF_W = 3
) (
    input  acc_size_e          size_i,
    input  byte_order_e        order_i,
    input  logic               sign_ext_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [8*LANES-1:0] rdata_i,
    output logic [8*LANES-1:0] value_o
);
    logic [3:0] nbytes;
    logic [7:0] field [LANES];
    logic [3:0] top_idx;
    logic       fill_bit;

    always_comb nbytes = size_bytes(size_i);

    for (genvar i = 0; i < LANES; i++) begin : g_pick
        logic [3:0] rel;
        logic [3:0] lane;
        always_comb begin
            rel  = value_index(4'(i), nbytes, order_i);
            lane = 4'(offset_i) + rel;
            field[i] = (4'(i) < nbytes) ? rdata_i[lane[OFF_W-1:0]*8 +: 8] : 8'h00;
        end
    end

    always_comb begin
        top_idx  = nbytes - 4'd1;
        fill_bit = sign_ext_i & field[top_idx[OFF_W-1:0]][7];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        always_comb value_o[i*8 +: 8] = (4'(i) < nbytes) ? field[i] : {8{fill_bit}};
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_signed,
    input  logic [1:0]        req_size,
    input  logic              req_big_endian,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_wbe,
    output logic [DATA_W-1:0] ld_result,
    output logic              ld_valid,
    output logic              align_fault
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    if (DATA_W != 64) begin : g_width_check
        $error("lsu_lane_unit supports a 64-bit word only");
    end

    acc_ctrl_t        ctrl;
    logic [OFF_W-1:0] offset;
    logic             aligned;
    logic             store_en;
    logic [DATA_W-1:0] load_value;
    load_rsp_t        rsp_q;

    always_comb begin
        ctrl.valid    = req_valid;
        ctrl.store    = req_store;
        ctrl.sign_ext = req_signed;
        ctrl.size     = acc_size_e'(req_size);
        ctrl.order    = byte_order_e'(req_big_endian);
        offset        = req_addr[OFF_W-1:0];
    end

    lsu_align_chk #(.OFF_W(OFF_W)) u_align (
        .size_i    (ctrl.size),
        .offset_i  (offset),
        .aligned_o (aligned)
    );

    always_comb store_en = ctrl.valid && ctrl.store && aligned;

    lsu_store_lanes #(.LANES(LANES), .OFF_W(OFF_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .en_i     (store_en),
        .size_i   (ctrl.size),
        .order_i  (ctrl.order),
        .offset_i (offset),
        .data_i   (req_wdata),
        .wdata_o  (mem_wdata),
        .wbe_o    (mem_wbe)
    );

    lsu_load_extract #(.LANES(LANES), .OFF_W(OFF_W)) u_load (
        .size_i     (ctrl.size),
        .order_i    (ctrl.order),
        .sign_ext_i (ctrl.sign_ext),
        .offset_i   (offset),
        .rdata_i    (mem_rdata),
        .value_o    (load_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.fault <= ctrl.valid && !aligned;
            rsp_q.valid <= ctrl.valid && !ctrl.store && aligned;
            if (ctrl.valid && !ctrl.store && aligned) begin
                rsp_q.value <= load_value;
            end
        end
    end

    always_comb begin
        ld_result   = rsp_q.value;
        ld_valid    = rsp_q.valid;
        align_fault = rsp_q.fault;
    end

    // R3: every fault pulse comes from a misaligned request one cycle earlier
    assert_fault_source_R3: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> $past(req_valid && !aligned));

    // R3: a misaligned request never writes memory
    assert_fault_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !aligned) |-> (mem_wbe == '0));

    // R4: the load result holds across a fault
    assert_fault_holds_result_R4: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> ($stable(ld_result) && !ld_valid));

    // R12: a valid result follows an aligned load request
    assert_load_latency_R12: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(req_valid && !req_store && aligned));

    // R11: unsigned byte loads leave the upper bits clear
    assert_zero_extend_R11: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && $past(!req_signed && req_size == 2'd0)) |-> (ld_result[DATA_W-1:8] == '0));
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;

    typedef struct packed {
        logic        st;
        logic        big;
        logic        sgn;
        logic [1:0]  sz;
        logic [2:0]  off;
        logic [63:0] dat;
        logic [7:0]  wbe;
        logic [63:0] res;
        logic        flt;
    } vec_t;

    localparam logic [63:0] RD = 64'h8877_6655_4433_2291;
    localparam int NVEC = 19;

    // Loads: res is the expected ld_result. Stores: res is the expected mem_wdata.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,1'b1,2'd0,3'd0,RD,8'h00,64'hFFFF_FFFF_FFFF_FF91,1'b0}, // R1 R9 R11 signed byte
        '{1'b0,1'b0,1'b0,2'd0,3'd0,RD,8'h00,64'h0000_0000_0000_0091,1'b0}, // R11 unsigned byte
        '{1'b0,1'b0,1'b1,2'd1,3'd6,RD,8'h00,64'hFFFF_FFFF_FFFF_8877,1'b0}, // R9 half LE
        '{1'b0,1'b1,1'b0,2'd1,3'd6,RD,8'h00,64'h0000_0000_0000_7788,1'b0}, // R10 half BE
        '{1'b0,1'b0,1'b0,2'd2,3'd4,RD,8'h00,64'h0000_0000_8877_6655,1'b0}, // R9 word LE
        '{1'b0,1'b1,1'b1,2'd2,3'd0,RD,8'h00,64'hFFFF_FFFF_9122_3344,1'b0}, // R10 R11 word BE
        '{1'b0,1'b0,1'b0,2'd3,3'd0,RD,8'h00,64'h8877_6655_4433_2291,1'b0}, // R9 dword LE
        '{1'b0,1'b1,1'b0,2'd3,3'd0,RD,8'h00,64'h9122_3344_5566_7788,1'b0}, // R10 dword BE
        '{1'b0,1'b1,1'b1,2'd0,3'd5,RD,8'h00,64'h0000_0000_0000_0066,1'b0}, // R1 byte BE
        '{1'b0,1'b0,1'b1,2'd1,3'd3,RD,8'h00,64'h0000_0000_0000_0066,1'b1}, // R2 R4 misaligned load
        '{1'b1,1'b0,1'b0,2'd2,3'd0,64'h0000_0000_FFFF_0000,8'h0F,64'hFFFF_0000_FFFF_0000,1'b0}, // R6
        '{1'b1,1'b1,1'b0,2'd2,3'd4,64'h0000_0000_FFFF_0000,8'hF0,64'h0000_FFFF_0000_FFFF,1'b0}, // R7
        '{1'b1,1'b0,1'b0,2'd0,3'd5,64'h0000_0000_0000_00AB,8'h20,64'hABAB_ABAB_ABAB_ABAB,1'b0}, // R5 R8
        '{1'b1,1'b0,1'b0,2'd1,3'd2,64'hDEAD_BEEF_CAFE_1234,8'h0C,64'h1234_1234_1234_1234,1'b0}, // R8 LE
        '{1'b1,1'b1,1'b0,2'd1,3'd2,64'hDEAD_BEEF_CAFE_1234,8'h0C,64'h3412_3412_3412_3412,1'b0}, // R8 BE
        '{1'b1,1'b1,1'b0,2'd3,3'd0,64'h0102_0304_0506_0708,8'hFF,64'h0807_0605_0403_0201,1'b0}, // R7 dword
        '{1'b1,1'b0,1'b0,2'd3,3'd0,64'h0102_0304_0506_0708,8'hFF,64'h0102_0304_0506_0708,1'b0}, // R6 dword
        '{1'b1,1'b0,1'b0,2'd2,3'd2,64'h1111_2222_3333_4444,8'h00,64'h0,1'b1}, // R2 R3 misaligned word
        '{1'b1,1'b1,1'b0,2'd3,3'd4,64'h1111_2222_3333_4444,8'h00,64'h0,1'b1}  // R2 R3 misaligned dword
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_signed, req_big_endian;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [63:0] req_wdata, mem_rdata;
    logic [63:0] mem_wdata, ld_result;
    logic [7:0]  mem_wbe;
    logic        ld_valid, align_fault;

    int checks = 0;
    int fails  = 0;
    logic [63:0] last_ld;

    always #2 clk = ~clk;

    lsu_lane_unit u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_store(req_store), .req_signed(req_signed),
        .req_size(req_size), .req_big_endian(req_big_endian), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
        .ld_result(ld_result), .ld_valid(ld_valid), .align_fault(align_fault)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_store = 1'b0; req_signed = 1'b0; req_big_endian = 1'b0;
        req_size = 2'd0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_store = v.st; req_signed = v.sgn; req_big_endian = v.big;
        req_size = v.sz; req_addr = 32'hABCD_1230 | 32'(v.off);
        req_wdata = v.st ? v.dat : 64'h5A5A_5A5A_5A5A_5A5A;
        mem_rdata = v.st ? 64'h0 : v.dat;
        #1;
        check(mem_wbe == v.wbe, "R5 strobes", 64'(mem_wbe), 64'(v.wbe));
        if (v.st && !v.flt) check(mem_wdata == v.res, "R6/R7/R8 store data", mem_wdata, v.res);
        @(posedge clk); #1;
        check(align_fault == v.flt, "R2/R3 fault flag", 64'(align_fault), 64'(v.flt));
        check(ld_valid == (!v.st && !v.flt), "R12 ld_valid", 64'(ld_valid), 64'(!v.st && !v.flt));
        if (!v.st) begin
            check(ld_result == v.res, "R9/R10/R11/R4 load result", ld_result, v.res);
            last_ld = v.res;
        end else begin
            check(ld_result == last_ld, "R4 store leaves load result", ld_result, last_ld);
        end
    endtask

    initial begin : watchdog
        #200000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R12: reset state
        check(ld_result == 64'h0, "R12 reset ld_result", ld_result, 64'h0);
        check(ld_valid == 1'b0, "R12 reset ld_valid", 64'(ld_valid), 64'h0);
        check(align_fault == 1'b0, "R12 reset fault", 64'(align_fault), 64'h0);
        last_ld = 64'h0;

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R3: fault lasts one cycle; R5: no strobes when req_valid is low
        @(negedge clk);
        idle_inputs();
        req_store = 1'b1; req_size = 2'd3; req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        #1;
        check(mem_wbe == 8'h00, "R5 idle store strobes", 64'(mem_wbe), 64'h0);
        @(posedge clk); #1;
        check(align_fault == 1'b0, "R3 fault single cycle", 64'(align_fault), 64'h0);
        check(ld_valid == 1'b0, "R12 idle ld_valid", 64'(ld_valid), 64'h0);

        // R5: loads never raise strobes even when aligned
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_size = 2'd3; mem_rdata = RD;
        #1;
        check(mem_wbe == 8'h00, "R5 load strobes", 64'(mem_wbe), 64'h0);
        @(posedge clk); #1;
        check(ld_result == RD, "R9 dword load", ld_result, RD);

        // R12: reset mid-run clears the result
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); #1;
        check(ld_result == 64'h0, "R12 mid-run reset ld_result", ld_result, 64'h0);
        check(ld_valid == 1'b0, "R12 mid-run reset ld_valid", 64'(ld_valid), 64'h0);
        @(negedge clk); rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule